// File: doc/BRIEF.md
# Dual-Converter Trigger Scheduler

This block sits between the trigger sources and two conversion sequencers, one acting as master and one as slave. A single four-bit mode code, taken from the master's side, decides how the two sequencers are started. Each sequencer has a regular path and an injected path, and each path has its own start strobe. For each trigger the block emits single-cycle start strobes. These strobes can start both sequencers together, start them one after the other with a fixed stagger, alternate between them, or pass each sequencer's own trigger straight through.

The regular group and the injected group are scheduled separately. The regular group can be independent, simultaneous, fast interleaved or slow interleaved. The injected group can be independent, simultaneous or alternating. A combined mode code sets one behaviour for each group at the same time.

Triggers that cannot be honoured are dropped. This happens when a trigger arrives during a staggered sequence, or when a simultaneous start is requested while a converter reports busy. Each dropped trigger sets a sticky overrun flag. All strobes leave the block through one register stage.

Top module: `dual_trig_sched`

## Requirements
- R1: After reset all four start strobes and `overrun_o` are low.
- R2: The mode codes map to a (regular, injected) pair as follows:
  - 0: (independent, independent)
  - 1: (simultaneous, simultaneous)
  - 2: (simultaneous, alternate)
  - 3: (fast, simultaneous)
  - 4: (slow, simultaneous)
  - 5: (independent, simultaneous)
  - 6: (simultaneous, independent)
  - 7: (fast, independent)
  - 8: (slow, independent)
  - 9: (independent, alternate)
- R3: In an independent group, a trigger on a converter's own input at the clock edge of cycle t gives that converter's start strobe for the group in cycle t+1 and no other strobe.
- R4: In a simultaneous group, a master trigger at edge t raises both converters' strobes for that group in cycle t+1. The slave's trigger input for that group has no effect.
- R5: Fast interleaved (regular group): a master regular trigger at edge t gives the master regular strobe at t+1 and the slave regular strobe at t+1+FAST_GAP (default 7).
- R6: Slow interleaved (regular group): a master regular trigger at edge t gives master strobes at t+1 and t+1+2*SLOW_GAP, and a slave strobe at t+1+SLOW_GAP (default 14).
- R7: Alternate (injected group): successive master injected triggers start the master, then the slave, then the master again, and so on. The slave's injected trigger input has no effect.
- R8: A change of mode code returns the alternation pointer to the master and cancels any staggered sequence in progress.
- R9: A regular trigger that arrives while a staggered sequence is still running is dropped. It produces no strobe and sets `overrun_o`. The flag stays set until reset.
- R10: A simultaneous-group trigger that arrives while `busy_m_i` or `busy_s_i` is high produces no strobe and sets `overrun_o`.
- R11: In a combined mode the two groups act concurrently. In mode 3, a regular and an injected master trigger at the same edge give both injected strobes and the master regular strobe at t+1, then the slave regular strobe FAST_GAP cycles later.
- R12: Mode codes 10 to 15 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Dual mode code (see R2) |
| reg_trig_m_i | input | 1 | Master regular trigger |
| reg_trig_s_i | input | 1 | Slave regular trigger (used only in independent regular group) |
| inj_trig_m_i | input | 1 | Master injected trigger |
| inj_trig_s_i | input | 1 | Slave injected trigger (used only in independent injected group) |
| busy_m_i | input | 1 | Master converter busy |
| busy_s_i | input | 1 | Slave converter busy |
| reg_start_m_o | output | 1 | Master regular start strobe |
| reg_start_s_o | output | 1 | Slave regular start strobe |
| inj_start_m_o | output | 1 | Master injected start strobe |
| inj_start_s_o | output | 1 | Slave injected start strobe |
| overrun_o | output | 1 | Sticky dropped-trigger flag |

## Verification
The hardest situations to reach are the second master strobe of a slow-interleaved sequence, which comes 29 cycles after the trigger, and a trigger that lands in the middle of a sequence. The stimulus places a second trigger a few cycles into a fast sequence. It then confirms that the only strobes produced belong to the first sequence, and that the overrun flag rises and stays set. The pointer reset is reached by firing one alternate trigger in mode 2, switching to mode 9, and showing that the next injected trigger goes to the master again.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [1:0] {
    RG_IND  = 2'd0,
    RG_SIM  = 2'd1,
    RG_FAST = 2'd2,
    RG_SLOW = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    IG_IND = 2'd0,
    IG_SIM = 2'd1,
    IG_ALT = 2'd2
  } inj_kind_e;

  localparam int MODE_W = 4;

  function automatic reg_kind_e reg_kind_of(input logic [MODE_W-1:0] m);
    case (m)
      4'd1, 4'd2, 4'd6: reg_kind_of = RG_SIM;
      4'd3, 4'd7:       reg_kind_of = RG_FAST;
      4'd4, 4'd8:       reg_kind_of = RG_SLOW;
      default:          reg_kind_of = RG_IND;
    endcase
  endfunction

  function automatic inj_kind_e inj_kind_of(input logic [MODE_W-1:0] m);
    case (m)
      4'd1, 4'd3, 4'd4, 4'd5: inj_kind_of = IG_SIM;
      4'd2, 4'd9:             inj_kind_of = IG_ALT;
      default:                inj_kind_of = IG_IND;
    endcase
  endfunction

endpackage

// File: rtl/dts_mode_decode.sv
module dts_mode_decode
  import dts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output reg_kind_e         reg_kind_o,
  output inj_kind_e         inj_kind_o,
  output logic              chg_o
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_i;
  end

  assign chg_o      = (mode_i != mode_q);
  assign reg_kind_o = reg_kind_of(mode_i);
  assign inj_kind_o = inj_kind_of(mode_i);

  // R8: a detected change is absorbed into the held code one cycle later
  p_chg_settles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |=> (mode_q == $past(mode_i)));

endmodule

// File: rtl/dts_stagger.sv
module dts_stagger #(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic fast_en_i,
  input  logic slow_en_i,
  input  logic cancel_i,
  output logic start_m_o,
  output logic start_s_o,
  output logic drop_o
);

  localparam int MAXG = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int CW   = $clog2(MAXG + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_S, ST_M2} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          slow_q, slow_d;
  logic          en, free;

  assign en   = fast_en_i | slow_en_i;
  assign free = (st_q == ST_IDLE) | cancel_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    slow_d    = slow_q;
    start_m_o = 1'b0;
    start_s_o = 1'b0;
    drop_o    = 1'b0;
    if (cancel_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_S: begin
          if (cnt_q == CW'(1)) begin
            start_s_o = 1'b1;
            if (slow_q) begin
              st_d  = ST_M2;
              cnt_d = CW'(SLOW_GAP);
            end else begin
              st_d  = ST_IDLE;
              cnt_d = '0;
            end
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        ST_M2: begin
          if (cnt_q == CW'(1)) begin
            start_m_o = 1'b1;
            st_d      = ST_IDLE;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: ;
      endcase
    end
    if (trig_i && en) begin
      if (free) begin
        start_m_o = 1'b1;
        st_d      = ST_S;
        cnt_d     = slow_en_i ? CW'(SLOW_GAP) : CW'(FAST_GAP);
        slow_d    = slow_en_i;
      end else begin
        drop_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
    end
  end

  // R5: the wait counter steps down by one each cycle of the slave wait
  p_gap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_S && cnt_q > CW'(1) && !cancel_i && !(trig_i && en))
      |=> (st_q == ST_S && cnt_q == $past(cnt_q) - CW'(1)));

  // R6: the closing master start returns the sequencer to idle
  p_m2_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_M2 && cnt_q == CW'(1) && !cancel_i && !(trig_i && en))
      |=> (st_q == ST_IDLE));

  // R8: a cancel leaves no sequence running unless a new one starts
  p_cancel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_i && !(trig_i && en)) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/dts_alternator.sv
module dts_alternator (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic chg_i,
  output logic start_m_o,
  output logic start_s_o
);

  logic ptr_q, ptr_d, eff;

  assign eff       = chg_i ? 1'b0 : ptr_q;
  assign start_m_o = fire_i & ~eff;
  assign start_s_o = fire_i &  eff;
  assign ptr_d     = fire_i ? ~eff : eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  // R7: every alternate trigger hands the next turn to the other side
  p_alt_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !chg_i) |=> (ptr_q != $past(ptr_q)));

  // R8: a mode change with no trigger leaves the pointer on the master
  p_alt_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_i && !fire_i) |=> !ptr_q);

endmodule

// File: rtl/dual_trig_sched.sv
module dual_trig_sched
  import dts_pkg::*;
#(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  mode_i,
  input  logic        reg_trig_m_i,
  input  logic        reg_trig_s_i,
  input  logic        inj_trig_m_i,
  input  logic        inj_trig_s_i,
  input  logic        busy_m_i,
  input  logic        busy_s_i,
  output logic        reg_start_m_o,
  output logic        reg_start_s_o,
  output logic        inj_start_m_o,
  output logic        inj_start_s_o,
  output logic        overrun_o
);

  reg_kind_e rk;
  inj_kind_e ik;
  logic      chg;
  logic      stg_m, stg_s, stg_drop;
  logic      alt_m, alt_s;
  logic      rm_d, rs_d, im_d, is_d;
  logic      r_drop, i_drop, sim_ok;

  dts_mode_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .reg_kind_o (rk),
    .inj_kind_o (ik),
    .chg_o      (chg)
  );

  dts_stagger #(.FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)) u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (reg_trig_m_i),
    .fast_en_i (rk == RG_FAST),
    .slow_en_i (rk == RG_SLOW),
    .cancel_i  (chg),
    .start_m_o (stg_m),
    .start_s_o (stg_s),
    .drop_o    (stg_drop)
  );

  dts_alternator u_alt (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (ik == IG_ALT && inj_trig_m_i),
    .chg_i     (chg),
    .start_m_o (alt_m),
    .start_s_o (alt_s)
  );

  assign sim_ok = ~busy_m_i & ~busy_s_i;

  always_comb begin
    rm_d   = 1'b0;
    rs_d   = 1'b0;
    r_drop = 1'b0;
    case (rk)
      RG_IND: begin
        rm_d = reg_trig_m_i;
        rs_d = reg_trig_s_i;
      end
      RG_SIM: begin
        rm_d   = reg_trig_m_i & sim_ok;
        rs_d   = reg_trig_m_i & sim_ok;
        r_drop = reg_trig_m_i & ~sim_ok;
      end
      default: begin
        rm_d = stg_m;
        rs_d = stg_s;
      end
    endcase
  end

  always_comb begin
    im_d   = 1'b0;
    is_d   = 1'b0;
    i_drop = 1'b0;
    case (ik)
      IG_SIM: begin
        im_d   = inj_trig_m_i & sim_ok;
        is_d   = inj_trig_m_i & sim_ok;
        i_drop = inj_trig_m_i & ~sim_ok;
      end
      IG_ALT: begin
        im_d = alt_m;
        is_d = alt_s;
      end
      default: begin
        im_d = inj_trig_m_i;
        is_d = inj_trig_s_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_start_m_o <= 1'b0;
      reg_start_s_o <= 1'b0;
      inj_start_m_o <= 1'b0;
      inj_start_s_o <= 1'b0;
      overrun_o     <= 1'b0;
    end else begin
      reg_start_m_o <= rm_d;
      reg_start_s_o <= rs_d;
      inj_start_m_o <= im_d;
      inj_start_s_o <= is_d;
      if (r_drop | i_drop | stg_drop) overrun_o <= 1'b1;
    end
  end

  // R3: an independent regular master trigger appears one cycle later
  p_ind_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == RG_IND && reg_trig_m_i) |=> reg_start_m_o);

  // R4: a simultaneous regular trigger with both converters idle starts both
  p_sim_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == RG_SIM && reg_trig_m_i && !busy_m_i && !busy_s_i)
      |=> (reg_start_m_o && reg_start_s_o));

  // R9: a trigger dropped by the staggered sequencer raises the flag
  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stg_drop |=> overrun_o);

  // R9: the flag never clears outside reset
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R10: a busy converter blocks a simultaneous regular start
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == RG_SIM && reg_trig_m_i && (busy_m_i || busy_s_i))
      |=> (!reg_start_m_o && overrun_o));

endmodule

// File: tb/sim_dual_trig_sched.sv
`timescale 1ns/1ps
module sim_dual_trig_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_i = 4'd0;
  logic       reg_trig_m_i = 0, reg_trig_s_i = 0, inj_trig_m_i = 0, inj_trig_s_i = 0;
  logic       busy_m_i = 0, busy_s_i = 0;
  logic       reg_start_m_o, reg_start_s_o, inj_start_m_o, inj_start_s_o, overrun_o;

  dual_trig_sched u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .reg_trig_m_i(reg_trig_m_i), .reg_trig_s_i(reg_trig_s_i),
    .inj_trig_m_i(inj_trig_m_i), .inj_trig_s_i(inj_trig_s_i),
    .busy_m_i(busy_m_i), .busy_s_i(busy_s_i),
    .reg_start_m_o(reg_start_m_o), .reg_start_s_o(reg_start_s_o),
    .inj_start_m_o(inj_start_m_o), .inj_start_s_o(inj_start_s_o),
    .overrun_o(overrun_o)
  );

  always #2 clk = ~clk;

  typedef struct { int cyc; logic [3:0] v; } exp_t;
  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_en = 0;
  bit    finished = 0;
  string req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // vector order: {reg_m, reg_s, inj_m, inj_s}
  task automatic push(input int c, input logic [3:0] v);
    exp_t e;
    if (q.size() > 0 && q[q.size()-1].cyc == c) q[q.size()-1].v = q[q.size()-1].v | v;
    else begin e.cyc = c; e.v = v; q.push_back(e); end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [3:0] exp_v;
      logic [3:0] act_v;
      exp_v = 4'b0;
      while (q.size() > 0 && q[0].cyc < cyc) begin
        errors++; checks++;
        $display("FAIL %s: expected strobe %b at cycle %0d never checked (actual none, expected %b)",
                 req, q[0].v, q[0].cyc, q[0].v);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_v = q[0].v;
        void'(q.pop_front());
      end
      act_v = {reg_start_m_o, reg_start_s_o, inj_start_m_o, inj_start_s_o};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s: cycle %0d strobes actual=%b expected=%b", req, cyc, act_v, exp_v);
      end
    end
  end

  task automatic chk_ovr(input logic e, input string r);
    @(negedge clk);
    checks++;
    if (overrun_o !== e) begin
      errors++;
      $display("FAIL %s: overrun actual=%b expected=%b", r, overrun_o, e);
    end
  endtask

  task automatic do_reset();
    mon_en = 0;
    q.delete();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    mon_en = 1;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(posedge clk); #1 mode_i = m;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // pulse triggers {reg_m, reg_s, inj_m, inj_s} for one cycle; returns drive cycle
  task automatic pulse(input logic [3:0] t, output int c);
    @(posedge clk); #1;
    c = cyc;
    {reg_trig_m_i, reg_trig_s_i, inj_trig_m_i, inj_trig_s_i} = t;
    @(posedge clk); #1;
    {reg_trig_m_i, reg_trig_s_i, inj_trig_m_i, inj_trig_s_i} = 4'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  initial begin
    int c;
    // R1: reset state
    req = "R1";
    do_reset();
    chk_ovr(1'b0, "R1");

    // R3: independent pass-through, each path
    req = "R3";
    set_mode(4'd0);
    pulse(4'b1000, c); push(c+1, 4'b1000); drain();
    pulse(4'b0100, c); push(c+1, 4'b0100); drain();
    pulse(4'b0010, c); push(c+1, 4'b0010); drain();
    pulse(4'b0001, c); push(c+1, 4'b0001); drain();

    // R12: reserved code acts as independent
    req = "R12";
    set_mode(4'd12);
    pulse(4'b0100, c); push(c+1, 4'b0100); drain();
    pulse(4'b0011, c); push(c+1, 4'b0011); drain();

    // R4: simultaneous both groups (mode 1), slave input ignored
    req = "R4";
    set_mode(4'd1);
    pulse(4'b1000, c); push(c+1, 4'b1100); drain();
    pulse(4'b0010, c); push(c+1, 4'b0011); drain();
    pulse(4'b0101, c); drain();
    chk_ovr(1'b0, "R4");

    // R7: alternate in mode 9, regular independent there (R2)
    req = "R7";
    set_mode(4'd9);
    pulse(4'b0010, c); push(c+1, 4'b0010); drain();
    pulse(4'b0010, c); push(c+1, 4'b0001); drain();
    pulse(4'b0010, c); push(c+1, 4'b0010); drain();
    pulse(4'b0001, c); drain();
    req = "R2";
    pulse(4'b0100, c); push(c+1, 4'b0100); drain();

    // R8: pointer returns to master on mode change (2 -> 9)
    req = "R8";
    set_mode(4'd2);
    pulse(4'b1000, c); push(c+1, 4'b1100); drain();
    pulse(4'b0010, c); push(c+1, 4'b0010); drain();
    set_mode(4'd9);
    pulse(4'b0010, c); push(c+1, 4'b0010); drain();

    // R5: fast interleaved (mode 7)
    req = "R5";
    set_mode(4'd7);
    pulse(4'b1000, c); push(c+1, 4'b1000); push(c+8, 4'b0100); drain();

    // R6: slow interleaved (mode 8)
    req = "R6";
    set_mode(4'd8);
    pulse(4'b1000, c); push(c+1, 4'b1000); push(c+15, 4'b0100); push(c+29, 4'b1000); drain();

    // R11: mode 3, regular fast with injected simultaneous at once
    req = "R11";
    set_mode(4'd3);
    pulse(4'b1010, c); push(c+1, 4'b1011); push(c+8, 4'b0100); drain();
    chk_ovr(1'b0, "R11");

    // R9: trigger during a fast sequence is dropped, flag sticks
    req = "R9";
    set_mode(4'd7);
    pulse(4'b1000, c); push(c+1, 4'b1000); push(c+8, 4'b0100);
    repeat (2) @(posedge clk);
    pulse(4'b1000, c);
    drain();
    chk_ovr(1'b1, "R9");
    repeat (10) @(posedge clk);
    chk_ovr(1'b1, "R9");

    // R10: busy blocks a simultaneous start
    req = "R1";
    do_reset();
    chk_ovr(1'b0, "R1");
    req = "R10";
    set_mode(4'd6);
    busy_s_i = 1'b1;
    pulse(4'b1000, c);
    drain();
    chk_ovr(1'b1, "R10");
    busy_s_i = 1'b0;
    pulse(4'b1000, c); push(c+1, 4'b1100); drain();

    summary();
  end

endmodule